// File: doc/BRIEF.md
# Fault campaign result classifier

This block sits on the tester side of a fault-injection or beam campaign against a triplicated design. For every run it takes the voted output word, the 3-bit status reported by the voter logic and a golden reference word. It compares the voted word with the golden word on every run, whatever the status says. From that comparison and the status it assigns the run to one category and advances a saturating event counter for that category.

The block also supports two-run experiments. A fault is injected during a first run, and the design is then run a second time without any change. The block keeps the first-run outcome. When the matching second-run result arrives, it sorts the pair by how the two outcomes relate. This separates faults that only show up after the fault has been applied, faults that disappear on the rerun, and faults that corrupt both runs. The last group is further split into identical and differing wrong outputs.

A one-cycle category code follows each accepted result. A synchronous clear restarts a campaign.

Top module: `fault_outcome_sorter`

## Requirements
- R1: A run whose status is 1, 2 or 3 and whose voted word equals the golden word gets category code 1 and increments `detected_cnt_o`.
- R2: A run whose status is 5, 6 or 7 and whose voted word equals the golden word gets category code 2 and increments `false_det_cnt_o`.
- R3: A run whose status is 0 and whose voted word differs from the golden word gets category code 3 and increments `undetected_cnt_o`.
- R4: A run whose status is 0 and whose voted word equals the golden word gets category code 0 and increments `clean_cnt_o`.
- R5: Every other run gets category code 4 and increments `other_cnt_o`. This covers status 4 with any output, and status 1 to 3 or 5 to 7 with a wrong output.
- R6: `cat_valid_o` is high, and `cat_o` holds the run's category code, in exactly the cycle after a cycle in which `res_valid_i` is high and `clear_i` is low. In every other cycle `cat_valid_o` is low.
- R7: The voted and golden words are compared over their full width, so a difference in only bit 0 or only the top bit counts as a wrong output.
- R8: An accepted result with `second_run_i` low stores that run's correctness and voted word. The next accepted result with `second_run_i` high closes the pair. A pair with a correct first run and a wrong second run increments `late_err_cnt_o`. A pair with a wrong first run and a correct second run increments `transient_cnt_o`. A pair with two correct runs changes no pair counter.
- R9: A pair in which both runs are wrong increments `both_same_cnt_o` when the two voted words are equal, and `both_diff_cnt_o` otherwise.
- R10: A second-run result with no stored first run changes no pair counter. A pair, once closed, is not closed again. Second-run results are still classified per run as in R1 to R5.
- R11: Every counter stops at its maximum value 2^CNT_W-1 and does not wrap.
- R12: `clear_i` synchronously zeroes all counters and discards any stored first run. A result presented together with `clear_i` is neither counted nor reported.
- R13: After reset all counters are zero and `cat_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous campaign clear |
| res_valid_i | input | 1 | One run result is present this cycle |
| second_run_i | input | 1 | Result belongs to the rerun of a pair |
| voted_i | input | DATA_W | Voted output word of the run |
| golden_i | input | DATA_W | Expected output word |
| status_i | input | 3 | Voter status: 0 agree, 1-3 dissenting replica, 4 all differ, 5-7 reserved |
| cat_valid_o | output | 1 | Category code valid |
| cat_o | output | 3 | Category code 0 to 4 |
| clean_cnt_o | output | CNT_W | Clean runs |
| detected_cnt_o | output | CNT_W | Detected errors |
| false_det_cnt_o | output | CNT_W | Falsely detected errors |
| undetected_cnt_o | output | CNT_W | Undetected errors |
| other_cnt_o | output | CNT_W | Unclassified runs |
| late_err_cnt_o | output | CNT_W | Pairs: first correct, second wrong |
| transient_cnt_o | output | CNT_W | Pairs: first wrong, second correct |
| both_same_cnt_o | output | CNT_W | Pairs: both wrong, same word |
| both_diff_cnt_o | output | CNT_W | Pairs: both wrong, different words |

## Verification
The directed cases cover each status value with a matching output and with a wrong output. This separates the detected, falsely detected, undetected, clean and other categories. Single-bit differences at the lowest and highest bit show that the whole word is compared.

Pair sequences cover correct/wrong, wrong/correct, correct/correct, and wrong/wrong with equal and with unequal words. Orphan and repeated second runs show that a pair is closed at most once.

Random runs mix all status codes, matching and wrong words and both run indices, with occasional clears. A long clean streak shows that the counters saturate instead of wrapping.

// File: rtl/fos_pkg.sv
package fos_pkg;
  localparam int CAT_W        = 3;
  localparam int NUM_RUN_CAT  = 5;
  localparam int NUM_PAIR_CAT = 4;
  localparam int NUM_CNT      = NUM_RUN_CAT + NUM_PAIR_CAT;

  typedef enum logic [CAT_W-1:0] {
    CAT_CLEAN = 3'd0,
    CAT_DET   = 3'd1,
    CAT_FALSE = 3'd2,
    CAT_UNDET = 3'd3,
    CAT_OTHER = 3'd4
  } run_cat_e;

  // counter slots after the per-run categories
  localparam int IDX_LATE  = NUM_RUN_CAT + 0;
  localparam int IDX_TRANS = NUM_RUN_CAT + 1;
  localparam int IDX_SAME  = NUM_RUN_CAT + 2;
  localparam int IDX_DIFF  = NUM_RUN_CAT + 3;
endpackage

// File: rtl/fos_run_classify.sv
module fos_run_classify
  import fos_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] voted_i,
  input  logic [DATA_W-1:0] golden_i,
  input  logic [2:0]        status_i,
  output logic              wrong_o,
  output run_cat_e          cat_o
);
  always_comb begin
    wrong_o = (voted_i != golden_i);
    unique case (status_i)
      3'd0:               cat_o = wrong_o ? CAT_UNDET : CAT_CLEAN;
      3'd1, 3'd2, 3'd3:   cat_o = wrong_o ? CAT_OTHER : CAT_DET;
      3'd4:               cat_o = CAT_OTHER;
      default:            cat_o = wrong_o ? CAT_OTHER : CAT_FALSE;
    endcase
  end
endmodule

// File: rtl/fos_pair_tracker.sv
module fos_pair_tracker #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              accept_i,
  input  logic              second_i,
  input  logic              wrong_i,
  input  logic [DATA_W-1:0] voted_i,
  output logic              late_o,
  output logic              trans_o,
  output logic              same_o,
  output logic              diff_o
);
  logic              pend_q;
  logic              first_wrong_q;
  logic [DATA_W-1:0] first_word_q;
  logic              close_pair;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= 1'b0;
      first_wrong_q <= 1'b0;
      first_word_q  <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (accept_i) begin
      if (!second_i) begin
        pend_q        <= 1'b1;
        first_wrong_q <= wrong_i;
        first_word_q  <= voted_i;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  assign close_pair = accept_i && second_i && pend_q;

  always_comb begin
    late_o  = close_pair && !first_wrong_q && wrong_i;
    trans_o = close_pair && first_wrong_q && !wrong_i;
    same_o  = close_pair && first_wrong_q && wrong_i && (voted_i == first_word_q);
    diff_o  = close_pair && first_wrong_q && wrong_i && (voted_i != first_word_q);
  end
endmodule

// File: rtl/fos_sat_counter.sv
module fos_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        q_o <= '0;
    else if (clr_i)                     q_o <= '0;
    else if (inc_i && q_o != MAX_VAL)   q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/fault_outcome_sorter.sv
module fault_outcome_sorter
  import fos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              res_valid_i,
  input  logic              second_run_i,
  input  logic [DATA_W-1:0] voted_i,
  input  logic [DATA_W-1:0] golden_i,
  input  logic [2:0]        status_i,
  output logic              cat_valid_o,
  output logic [2:0]        cat_o,
  output logic [CNT_W-1:0]  clean_cnt_o,
  output logic [CNT_W-1:0]  detected_cnt_o,
  output logic [CNT_W-1:0]  false_det_cnt_o,
  output logic [CNT_W-1:0]  undetected_cnt_o,
  output logic [CNT_W-1:0]  other_cnt_o,
  output logic [CNT_W-1:0]  late_err_cnt_o,
  output logic [CNT_W-1:0]  transient_cnt_o,
  output logic [CNT_W-1:0]  both_same_cnt_o,
  output logic [CNT_W-1:0]  both_diff_cnt_o
);
  logic               accept;
  logic               wrong;
  run_cat_e           run_cat;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic               cat_valid_q;
  run_cat_e           cat_q;

  assign accept = res_valid_i && !clear_i;

  fos_run_classify #(.DATA_W(DATA_W)) u_classify (
    .voted_i  (voted_i),
    .golden_i (golden_i),
    .status_i (status_i),
    .wrong_o  (wrong),
    .cat_o    (run_cat)
  );

  fos_pair_tracker #(.DATA_W(DATA_W)) u_pair (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clear_i),
    .accept_i (accept),
    .second_i (second_run_i),
    .wrong_i  (wrong),
    .voted_i  (voted_i),
    .late_o   (inc[IDX_LATE]),
    .trans_o  (inc[IDX_TRANS]),
    .same_o   (inc[IDX_SAME]),
    .diff_o   (inc[IDX_DIFF])
  );

  for (genvar g = 0; g < NUM_RUN_CAT; g++) begin : g_run_inc
    assign inc[g] = accept && (run_cat == run_cat_e'(g));
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    fos_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc[g]),
      .q_o    (cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cat_valid_q <= 1'b0;
      cat_q       <= CAT_CLEAN;
    end else begin
      cat_valid_q <= accept;
      if (accept) cat_q <= run_cat;
    end
  end

  assign cat_valid_o      = cat_valid_q;
  assign cat_o            = cat_q;
  assign clean_cnt_o      = cnt[CAT_CLEAN];
  assign detected_cnt_o   = cnt[CAT_DET];
  assign false_det_cnt_o  = cnt[CAT_FALSE];
  assign undetected_cnt_o = cnt[CAT_UNDET];
  assign other_cnt_o      = cnt[CAT_OTHER];
  assign late_err_cnt_o   = cnt[IDX_LATE];
  assign transient_cnt_o  = cnt[IDX_TRANS];
  assign both_same_cnt_o  = cnt[IDX_SAME];
  assign both_diff_cnt_o  = cnt[IDX_DIFF];
endmodule

// File: rtl/fos_checker.sv
module fos_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              res_valid_i,
  input logic              second_run_i,
  input logic [DATA_W-1:0] voted_i,
  input logic [DATA_W-1:0] golden_i,
  input logic [2:0]        status_i,
  input logic              cat_valid_o,
  input logic [2:0]        cat_o,
  input logic [CNT_W-1:0]  clean_cnt_o,
  input logic [CNT_W-1:0]  detected_cnt_o,
  input logic [CNT_W-1:0]  false_det_cnt_o,
  input logic [CNT_W-1:0]  undetected_cnt_o,
  input logic [CNT_W-1:0]  other_cnt_o,
  input logic [CNT_W-1:0]  late_err_cnt_o,
  input logic [CNT_W-1:0]  transient_cnt_o,
  input logic [CNT_W-1:0]  both_same_cnt_o,
  input logic [CNT_W-1:0]  both_diff_cnt_o
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic acc;
  logic match;
  logic all_zero;
  assign acc      = res_valid_i && !clear_i;
  assign match    = (voted_i == golden_i);
  assign all_zero = (clean_cnt_o == '0) && (detected_cnt_o == '0) && (false_det_cnt_o == '0)
                 && (undetected_cnt_o == '0) && (other_cnt_o == '0) && (late_err_cnt_o == '0)
                 && (transient_cnt_o == '0) && (both_same_cnt_o == '0) && (both_diff_cnt_o == '0);

  p_cat_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> cat_valid_o);
  p_cat_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !cat_valid_o);
  p_detected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && match && status_i >= 3'd1 && status_i <= 3'd3) |=> (cat_o == 3'd1));
  p_false_det_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && match && status_i >= 3'd5) |=> (cat_o == 3'd2));
  p_undetected_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !match && status_i == 3'd0) |=> (cat_o == 3'd3));
  p_status4_other_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && status_i == 3'd4) |=> (cat_o == 3'd4));
  p_clear_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> all_zero);
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && clean_cnt_o == MAX_VAL) |=> (clean_cnt_o == MAX_VAL));
  p_pair_monotone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (late_err_cnt_o >= $past(late_err_cnt_o)));
  p_orphan_second_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc || !second_run_i) |=> $stable(both_diff_cnt_o) || $past(clear_i));
  p_undet_monotone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (undetected_cnt_o >= $past(undetected_cnt_o)));
endmodule

bind fault_outcome_sorter fos_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fos_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .clear_i          (clear_i),
  .res_valid_i      (res_valid_i),
  .second_run_i     (second_run_i),
  .voted_i          (voted_i),
  .golden_i         (golden_i),
  .status_i         (status_i),
  .cat_valid_o      (cat_valid_o),
  .cat_o            (cat_o),
  .clean_cnt_o      (clean_cnt_o),
  .detected_cnt_o   (detected_cnt_o),
  .false_det_cnt_o  (false_det_cnt_o),
  .undetected_cnt_o (undetected_cnt_o),
  .other_cnt_o      (other_cnt_o),
  .late_err_cnt_o   (late_err_cnt_o),
  .transient_cnt_o  (transient_cnt_o),
  .both_same_cnt_o  (both_same_cnt_o),
  .both_diff_cnt_o  (both_diff_cnt_o)
);

// File: tb/fault_outcome_sorter_tb_top.sv
module fault_outcome_sorter_tb_top;
  localparam int DW   = 16;
  localparam int CW   = 6;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NC   = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clear_i = 1'b0;
  logic          res_valid_i = 1'b0;
  logic          second_run_i = 1'b0;
  logic [DW-1:0] voted_i = '0;
  logic [DW-1:0] golden_i = '0;
  logic [2:0]    status_i = '0;
  logic          cat_valid_o;
  logic [2:0]    cat_o;
  logic [CW-1:0] act_cnt [NC];

  always #5 clk = ~clk;

  fault_outcome_sorter #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .clear_i          (clear_i),
    .res_valid_i      (res_valid_i),
    .second_run_i     (second_run_i),
    .voted_i          (voted_i),
    .golden_i         (golden_i),
    .status_i         (status_i),
    .cat_valid_o      (cat_valid_o),
    .cat_o            (cat_o),
    .clean_cnt_o      (act_cnt[0]),
    .detected_cnt_o   (act_cnt[1]),
    .false_det_cnt_o  (act_cnt[2]),
    .undetected_cnt_o (act_cnt[3]),
    .other_cnt_o      (act_cnt[4]),
    .late_err_cnt_o   (act_cnt[5]),
    .transient_cnt_o  (act_cnt[6]),
    .both_same_cnt_o  (act_cnt[7]),
    .both_diff_cnt_o  (act_cnt[8])
  );

  int            n_chk = 0;
  int            n_fail = 0;
  int            exp_cnt [NC];
  bit            pend = 0;
  bit            fwrong = 0;
  logic [DW-1:0] fword = '0;
  bit            exp_cv = 0;
  logic [2:0]    exp_cat = '0;
  string         cnt_tag [NC] = '{"R4 clean", "R1 detected", "R2 false_det", "R3 undetected",
                                  "R5 other", "R8 late", "R8 transient", "R9 same", "R9 diff"};

  function automatic logic [2:0] ref_cat(logic [2:0] st, bit wrong);
    if (st == 3'd0) return wrong ? 3'd3 : 3'd0;
    if (st <= 3'd3) return wrong ? 3'd4 : 3'd1;
    if (st == 3'd4) return 3'd4;
    return wrong ? 3'd4 : 3'd2;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic bump(int i);
    if (exp_cnt[i] < MAXC) exp_cnt[i]++;
  endtask

  task automatic check_all(string req);
    check({req, " R6 cat_valid"}, int'(cat_valid_o), int'(exp_cv));
    if (exp_cv) check({req, " cat"}, int'(cat_o), int'(exp_cat));
    for (int i = 0; i < NC; i++) check({req, " ", cnt_tag[i]}, int'(act_cnt[i]), exp_cnt[i]);
  endtask

  // drives one cycle of inputs right after a negedge, checks at the next negedge
  task automatic step(bit v, logic [DW-1:0] vw, logic [2:0] st, logic [DW-1:0] gw,
                      bit sec, bit clr, string req);
    bit wrong;
    logic [2:0] c;
    res_valid_i = v; voted_i = vw; status_i = st; golden_i = gw;
    second_run_i = sec; clear_i = clr;
    if (clr) begin
      for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
      pend = 0;
      exp_cv = 0;
    end else if (v) begin
      wrong = (vw != gw);
      c = ref_cat(st, wrong);
      bump(int'(c));
      exp_cv = 1;
      exp_cat = c;
      if (!sec) begin
        pend = 1; fwrong = wrong; fword = vw;
      end else begin
        if (pend) begin
          if (!fwrong && wrong) bump(5);
          else if (fwrong && !wrong) bump(6);
          else if (fwrong && wrong) bump((vw == fword) ? 7 : 8);
        end
        pend = 0;
      end
    end else begin
      exp_cv = 0;
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    logic [DW-1:0] g;
    logic [DW-1:0] w;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;

    // R13 reset state
    repeat (3) @(negedge clk);
    check_all("R13 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R13 after release");

    g = 16'h3c5a;
    // per-run categories
    step(1, g, 3'd0, g, 0, 0, "R4 status0 match");
    step(1, g ^ 16'h0100, 3'd0, g, 0, 0, "R3 status0 wrong");
    step(1, g, 3'd1, g, 0, 0, "R1 status1 match");
    step(1, g, 3'd3, g, 0, 0, "R1 status3 match");
    step(1, g, 3'd5, g, 0, 0, "R2 status5 match");
    step(1, g, 3'd7, g, 0, 0, "R2 status7 match");
    step(1, g, 3'd4, g, 0, 0, "R5 status4 match");
    step(1, g ^ 16'h0001, 3'd4, g, 0, 0, "R5 status4 wrong");
    step(1, g ^ 16'h0010, 3'd2, g, 0, 0, "R5 status2 wrong");
    step(1, g ^ 16'h0020, 3'd6, g, 0, 0, "R5 status6 wrong");
    // R7 full-width compare
    step(1, g ^ 16'h8000, 3'd0, g, 0, 0, "R7 msb only");
    step(1, g ^ 16'h0001, 3'd0, g, 0, 0, "R7 lsb only");
    step(0, g, 3'd0, g, 0, 0, "R6 idle");
    // R12 clear
    step(1, g, 3'd1, g, 0, 1, "R12 clear with valid");
    step(0, g, 3'd0, g, 0, 0, "R12 after clear");
    // R8 pairs
    step(1, g, 3'd0, g, 0, 0, "R8 first ok");
    step(1, g ^ 16'h0004, 3'd0, g, 1, 0, "R8 second wrong");
    step(1, g ^ 16'h0004, 3'd0, g, 0, 0, "R8 first wrong");
    step(1, g, 3'd0, g, 1, 0, "R8 second ok");
    step(1, g, 3'd0, g, 0, 0, "R8 first ok b");
    step(1, g, 3'd0, g, 1, 0, "R8 both ok");
    // R9 both wrong
    step(1, 16'h1111, 3'd0, g, 0, 0, "R9 first wrong");
    step(1, 16'h1111, 3'd0, g, 1, 0, "R9 same wrong");
    step(1, 16'h1111, 3'd0, g, 0, 0, "R9 first wrong b");
    step(1, 16'h2222, 3'd2, g, 1, 0, "R9 diff wrong");
    // R10 orphan and repeated second
    step(1, 16'h2222, 3'd0, g, 1, 0, "R10 orphan second");
    step(1, 16'h1111, 3'd0, g, 0, 0, "R10 first");
    step(1, 16'h1111, 3'd0, g, 1, 0, "R10 close");
    step(1, 16'h1111, 3'd0, g, 1, 0, "R10 repeat second");
    // R12 clear discards stored first
    step(1, g, 3'd0, g, 0, 0, "R12 first ok");
    step(0, g, 3'd0, g, 0, 1, "R12 clear");
    step(1, g ^ 16'h0002, 3'd0, g, 1, 0, "R12 second after clear");
    // R11 saturation
    for (int i = 0; i < MAXC + 8; i++) step(1, g, 3'd0, g, 0, 0, "R11 saturate");
    step(1, g, 3'd0, g, 0, 1, "R12 clear after sat");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      bit v, sec, clr;
      logic [2:0] st;
      int m;
      g   = DW'($urandom);
      m   = $urandom_range(0, 3);
      if (m == 0)      w = g;
      else if (m == 1) w = g ^ DW'(1 << $urandom_range(0, DW - 1));
      else if (m == 2) w = 16'ha5a5;
      else             w = ($urandom_range(0, 1) != 0) ? g : 16'h5a5a;
      st  = 3'($urandom_range(0, 7));
      v   = ($urandom_range(0, 4) != 0);
      sec = ($urandom_range(0, 1) != 0);
      clr = ($urandom_range(0, 99) < 2);
      step(v, w, st, g, sec, clr, "R1 R5 R8 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule